// File: doc/BRIEF.md
# Three-Wire Step Attenuator Programming Master

This block sits on the host side of a board and writes attenuation settings into digitally stepped RF attenuators that share one three-wire serial link: data, shift clock and latch enable. Each attenuator on the link has a strapped 3-bit address, so up to eight of them can share the same wires. A request carries a target address, an attenuation value in quarter-dB units (0 to 127, so 0 to 31.75 dB), and a step-size selector. The master builds a 16-bit frame from these fields and shifts it out least significant bit first. The low byte holds the attenuation code and the high byte holds the address. It then raises latch enable for a short pulse, and the addressed attenuator applies the new value.

All wire timing comes from one system-clock-period parameter. The minimum shift-clock high and low times, the maximum shift rate, data setup and hold, the gap from the last clock edge to the latch, and the latch pulse width are each rounded up to whole system cycles. Requests use a valid/ready handshake. Ready stays low for the whole transfer, and a one-cycle done pulse marks completion.

Top module: `atten_ser_master`

## Requirements
- R1: While reset is asserted and right after it, req_ready is 1 and ser_clk, ser_le and done are 0.
- R2: The 7-bit attenuation code is req_qdb when req_step is 0 (quarter-dB steps). It is req_qdb with bit 0 cleared when req_step is 1 (half-dB steps). It is req_qdb with bits 1:0 cleared when req_step is 2 or 3 (whole-dB steps).
- R3: Each transfer gives exactly 16 ser_clk rising edges, and each edge carries one frame bit, LSB first. Frame bits 6:0 are the code from R2 and bit 7 is 0. Bits 10:8 are req_addr and bits 15:11 are 0. For example, 18.25 dB (code 73) to address 3 gives frame 16'h0349.
- R4: ser_le is 0 whenever ser_clk is 1 or rises during a transfer.
- R5: With a 10 ns system clock, ser_clk stays high for at least 3 cycles and low for at least 3 cycles between rises. Consecutive rises are at least 10 cycles apart (at most 10 MHz).
- R6: ser_data is stable for at least one system cycle before each ser_clk rise and at least one cycle after it.
- R7: ser_le rises only after all 16 clock rises, with ser_clk low and at least one cycle after the last rise. It then stays high for exactly 3 cycles with a 10 ns system clock.
- R8: req_ready is 0 from the cycle after acceptance until ser_le has returned low. done is high for exactly one cycle, the first cycle after ser_le falls, and req_ready is 1 in that cycle.
- R9: req_valid asserted while a transfer is in progress is ignored: the frame in flight is unchanged and no extra transfer or done pulse follows.
- R10: When idle (req_ready high), ser_clk and ser_le are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle and able to accept a request |
| req_addr | input | 3 | Target attenuator address |
| req_qdb | input | 7 | Attenuation in quarter-dB units |
| req_step | input | 2 | Step size: 0 = 0.25 dB, 1 = 0.5 dB, 2/3 = 1 dB |
| ser_clk | output | 1 | Serial shift clock, idles low |
| ser_data | output | 1 | Serial data, sampled by the attenuator on ser_clk rise |
| ser_le | output | 1 | Latch enable pulse that commits the frame |
| done | output | 1 | One-cycle completion strobe |

## Verification
Most internal faults in this block show up quickly at the wires. A wrong bit index or shift register corrupts the reassembled frame, and the bench compares that frame with its own model at the done pulse of every transfer. A wrong phase count shows up at the very next clock edge as a high or low time that is too short, a rise-to-rise spacing that is too short, or a latch pulse of the wrong width. A state machine that leaves the latch or done at the wrong moment is caught within one cycle of that moment, by the latch-versus-clock and done-width checks.

// File: rtl/atten_ser_master.sv
module atten_ser_master #(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int T_SCLK_HI_NS  = 30,
  parameter int T_SCLK_LO_NS  = 30,
  parameter int T_SCLK_PER_NS = 100,
  parameter int T_SU_NS       = 10,
  parameter int T_HD_NS       = 10,
  parameter int T_LEAD_NS     = 10,
  parameter int T_LE_NS       = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [2:0] req_addr,
  input  logic [6:0] req_qdb,
  input  logic [1:0] req_step,
  output logic       ser_clk,
  output logic       ser_data,
  output logic       ser_le,
  output logic       done
);

  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int HI_CYC  = imax(ns2cyc(T_SCLK_HI_NS), ns2cyc(T_HD_NS));
  localparam int LO_CYC  = imax(imax(ns2cyc(T_SCLK_LO_NS), ns2cyc(T_SU_NS)),
                                ns2cyc(T_SCLK_PER_NS) - HI_CYC);
  localparam int GAP_CYC = ns2cyc(T_LEAD_NS);
  localparam int LE_CYC  = ns2cyc(T_LE_NS);
  localparam int MAX_CYC = imax(imax(HI_CYC, LO_CYC), imax(GAP_CYC, LE_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int FRAME_W = 16;

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_HIGH, S_GAP, S_LE} state_t;

  state_t                       state;
  logic [CNT_W-1:0]             cnt;
  logic [$clog2(FRAME_W)-1:0]   bitn;
  logic [FRAME_W-1:0]           shreg;
  logic                         done_q;
  logic [6:0]                   code;

  always_comb begin
    code = req_qdb;
    if (req_step == 2'd1)      code[0]   = 1'b0;
    else if (req_step != 2'd0) code[1:0] = 2'b00;
  end

  assign req_ready = (state == S_IDLE);
  assign ser_clk   = (state == S_HIGH);
  assign ser_le    = (state == S_LE);
  assign ser_data  = shreg[0];
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      shreg  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          shreg <= {5'b0, req_addr, 1'b0, code};
          bitn  <= '0;
          cnt   <= CNT_W'(LO_CYC - 1);
          state <= S_LOW;
        end
        S_LOW:
          if (cnt == '0) begin
            cnt   <= CNT_W'(HI_CYC - 1);
            state <= S_HIGH;
          end else cnt <= cnt - 1'b1;
        S_HIGH:
          if (cnt == '0) begin
            if (bitn == $clog2(FRAME_W)'(FRAME_W - 1)) begin
              cnt   <= CNT_W'(GAP_CYC - 1);
              state <= S_GAP;
            end else begin
              shreg <= shreg >> 1;
              bitn  <= bitn + 1'b1;
              cnt   <= CNT_W'(LO_CYC - 1);
              state <= S_LOW;
            end
          end else cnt <= cnt - 1'b1;
        S_GAP:
          if (cnt == '0) begin
            cnt   <= CNT_W'(LE_CYC - 1);
            state <= S_LE;
          end else cnt <= cnt - 1'b1;
        S_LE:
          if (cnt == '0) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_LE_APART_FROM_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_clk && ser_le)); // R4
  AST_CLK_HIGH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (HI_CYC > 1 && $rose(ser_clk)) |=> ser_clk); // R5
  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AFTER_LE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(ser_le) && !ser_le && req_ready)); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ser_le |-> !req_ready); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ser_clk && !ser_le)); // R10

endmodule

// File: tb/sim_atten_ser_master.sv
module sim_atten_ser_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_addr = '0;
  logic [6:0] req_qdb = '0;
  logic [1:0] req_step = '0;
  logic       ser_clk, ser_data, ser_le, done;

  always #5 clk = ~clk;

  atten_ser_master u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_qdb(req_qdb), .req_step(req_step),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le), .done(done)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;
  logic [15:0] exp_frame = '0;

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  function automatic logic [15:0] model(input logic [2:0] a, input logic [6:0] q,
                                        input logic [1:0] s);
    logic [6:0] c;
    c = q;
    if (s == 2'd1) c = {q[6:1], 1'b0};
    else if (s != 2'd0) c = {q[6:2], 2'b00};
    return {5'b0, a, 1'b0, c};
  endfunction

  always @(posedge clk) cyc++;

  // monitor
  logic p_sclk = 0, p_le = 0, p_data = 0, p_done = 0, hold_pend = 0, rise_data = 0;
  int hi_run = 0, lo_run = 0, le_run = 0, since_rise = 0, per_run = 0, nrise = 0;
  int done_cnt = 0;
  logic [15:0] got = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_clk && !p_sclk) begin
        chk(!ser_le, "R4 le low at clock rise", ser_le, 0);
        if (nrise > 0) begin
          chk(lo_run >= 3, "R5 clock low time", lo_run, 3);
          chk(per_run >= 10, "R5 rise-to-rise spacing", per_run, 10);
        end
        chk(ser_data == p_data, "R6 data setup", ser_data, p_data);
        if (nrise < 16) got[nrise] = ser_data;
        nrise++;
        since_rise = 0;
        per_run = 0;
        hold_pend = 1;
        rise_data = ser_data;
      end else if (hold_pend) begin
        chk(ser_data == rise_data, "R6 data hold", ser_data, rise_data);
        hold_pend = 0;
      end
      if (!ser_clk && p_sclk) chk(hi_run >= 3, "R5 clock high time", hi_run, 3);
      if (ser_le && !p_le) begin
        chk(!ser_clk && since_rise >= 1, "R7 le lead after last rise", since_rise, 1);
        chk(nrise == 16, "R7 le after all rises", nrise, 16);
      end
      if (!ser_le && p_le) chk(le_run == 3, "R7 le pulse width", le_run, 3);
      if (p_done) chk(!done, "R8 done one cycle", done, 0);
      if (done) begin
        done_cnt++;
        chk(got == exp_frame, "R2/R3 frame content", got, exp_frame);
        chk(nrise == 16, "R3 rise count", nrise, 16);
        chk(req_ready && !ser_le && p_le, "R8 ready with done after le falls",
            {req_ready, ser_le, p_le}, 3'b101);
        chk(!ser_clk, "R10 clock idle low", ser_clk, 0);
        nrise = 0;
        got = '0;
      end
      hi_run = ser_clk ? hi_run + 1 : 0;
      lo_run = ser_clk ? 0 : lo_run + 1;
      le_run = ser_le ? le_run + 1 : 0;
      since_rise++;
      per_run++;
    end
    p_sclk = ser_clk;
    p_le = ser_le;
    p_data = ser_data;
    p_done = done;
  end

  task automatic send(input logic [2:0] a, input logic [6:0] q, input logic [1:0] s);
    while (!req_ready) @(negedge clk);
    exp_frame = model(a, q, s);
    req_addr = a; req_qdb = q; req_step = s; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R8 ready low after accept", req_ready, 0);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk(req_ready && !ser_clk && !ser_le && !done, "R1 state in reset",
        {req_ready, ser_clk, ser_le, done}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !ser_clk && !ser_le && !done, "R1 state after reset",
        {req_ready, ser_clk, ser_le, done}, 4'b1000);
    chk(!ser_clk && !ser_le, "R10 idle lines", {ser_clk, ser_le}, 0);

    send(3'd3, 7'd73, 2'd0);
    chk(exp_frame == 16'h0349, "R3 worked example frame", exp_frame, 16'h0349);
    send(3'd0, 7'd127, 2'd0);
    send(3'd7, 7'd0, 2'd0);
    send(3'd5, 7'd127, 2'd1);
    send(3'd2, 7'd127, 2'd2);
    send(3'd6, 7'd3, 2'd3);
    send(3'd1, 7'd85, 2'd1);

    // R9: request while busy is ignored
    begin
      int d0;
      d0 = done_cnt;
      exp_frame = model(3'd4, 7'd42, 2'd0);
      req_addr = 3'd4; req_qdb = 7'd42; req_step = 2'd0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (20) @(negedge clk);
      req_addr = 3'd1; req_qdb = 7'd99; req_step = 2'd0; req_valid = 1'b1;
      repeat (50) @(negedge clk);
      req_valid = 1'b0;
      repeat (250) @(negedge clk);
      chk(done_cnt == d0 + 1, "R9 single transfer while busy", done_cnt, d0 + 1);
      chk(req_ready && !ser_clk && !ser_le, "R9 idle after ignored request",
          {req_ready, ser_clk, ser_le}, 3'b100);
    end

    for (int i = 0; i < 40; i++) begin
      send(3'($urandom), 7'($urandom), 2'($urandom));
      if ((i % 5) == 0) repeat (1 + ($urandom % 7)) @(negedge clk);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc == 100000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule